// File: doc/BRIEF.md
# Software Register Entry Sequence Detector

This block lives inside an asynchronous pseudo-SRAM model. It sees each completed access as one transfer on a request stream: a read or write flag, a 21-bit address and 16-bit write data. It watches for a fixed unlock pattern aimed at the highest address, 0x1FFFFF. The pattern has four steps:

- a read of that address;
- a second read of that address straight after it;
- a write of 0x0000 to that address, which selects the refresh configuration register;
- one more access to that address.

That fourth access reaches the configuration register and not memory. A write loads the low 16 bits of the register from the data bus. A read returns those bits.

Any other access type, any other address, a different selector value or an extra cycle breaks the pattern. In every such case the access is handled as ordinary memory. The block stores the single top-address word itself. For every other address it answers with a pass-through mark, so that the surrounding array serves the access.

Each accepted access produces one response record on a valid/ready result stream. Back-pressure works as follows:

- a request is accepted only while the result slot is empty or is being drained in the same cycle;
- a pending result holds its kind and data unchanged until it is taken.

The full 21-bit configuration register is also visible as a plain output.

Top module: `swre_unit`

## Requirements
- R1: A synchronous reset, active high, clears the result slot (`res_valid`=0), loads the configuration register with 21'h1A0003, clears the top word to 0 and returns the pattern tracker to its idle state.
- R2: A request is accepted on a clock edge where `cyc_valid` and `cyc_ready` are both 1, and `cyc_ready` is 1 exactly when the result slot is empty or `res_ready` is 1. While `res_valid`=1 and `res_ready`=0, `res_kind` and `res_data` hold their values.
- R3: An accepted access to any address other than 0x1FFFFF yields, on the next cycle, a result with kind 0 (pass-through) and data 0. It breaks any pattern in progress.
- R4: Outside a completed pattern, an access to 0x1FFFFF is an ordinary top-word access and yields kind 1. A read returns the stored word. A write stores `cyc_wdata` and returns data 0.
- R5: After read, read, write 0x0000 to 0x1FFFFF, a fourth write to 0x1FFFFF yields kind 2 and data 0. It loads register bits [15:0] from `cyc_wdata` and leaves the top word unchanged.
- R6: After read, read, write 0x0000 to 0x1FFFFF, a fourth read of 0x1FFFFF yields kind 2 with data equal to register bits [15:0].
- R7: Register bits [20:16] are never altered by this path.
- R8: Bit 4 of the register is the deep power-down enable. A software write always clears it, so this path never enables deep power-down.
- R9: A write in the first or second step, or a non-top access anywhere in the pattern, aborts it. The register then does not change, and the would-be fourth access is handled as ordinary.
- R10: A third-step write with data other than 0x0000 is stored as an ordinary top-word write. The tracker returns to idle and the register is untouched.
- R11: A mismatching cycle is re-evaluated from idle, so a read of 0x1FFFFF that breaks a pattern starts a new one as its first read.
- R12: After the fourth access the tracker is idle, and the following read of 0x1FFFFF is an ordinary kind 1 access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | Access request present |
| cyc_ready | output | 1 | Access request can be accepted |
| cyc_write | input | 1 | 1 = write access, 0 = read access |
| cyc_addr | input | 21 | Access address |
| cyc_wdata | input | 16 | Write data |
| res_valid | output | 1 | Result record present |
| res_ready | input | 1 | Result record taken |
| res_kind | output | 2 | 0 pass-through, 1 top word, 2 register |
| res_data | output | 16 | Read data, 0 for writes and pass-through |
| cfg_reg | output | 21 | Refresh configuration register |

## Verification
A tracker left in the wrong state shows up on the very next access to 0x1FFFFF:

- a tracker stuck past idle turns an ordinary top access into a kind 2 result;
- a tracker that missed an advance answers the fourth access with kind 1 and leaves `cfg_reg` unchanged.

Either way the error is visible one cycle after the deciding access is accepted. A fault in the register write path appears on `cfg_reg` in that same cycle, either as changed upper bits or as a set bit 4. A fault in the response stage shows as data that changes while the result is stalled.

// File: rtl/swre_pkg.sv
package swre_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE     = 2'd0,
    TRK_READ1    = 2'd1,
    TRK_READ2    = 2'd2,
    TRK_SELECTED = 2'd3
  } trk_state_e;

  typedef enum logic [1:0] {
    RSP_PASS = 2'd0,
    RSP_TOP  = 2'd1,
    RSP_REG  = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/swre_tracker.sv
module swre_tracker #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEL_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              is_write,
  input  logic              is_top,
  input  logic [DATA_W-1:0] wdata,
  output logic              reg_access
);
  import swre_pkg::*;

  trk_state_e state_q, state_d, restart_d;

  // a cycle that breaks the pattern is judged again as if from idle
  always_comb begin
    restart_d = (is_top && !is_write) ? TRK_READ1 : TRK_IDLE;
    state_d   = state_q;
    if (fire) begin
      unique case (state_q)
        TRK_IDLE:     state_d = restart_d;
        TRK_READ1:    state_d = (is_top && !is_write) ? TRK_READ2 : restart_d;
        TRK_READ2:    state_d = (is_top && is_write && wdata == SEL_CODE)
                                ? TRK_SELECTED : restart_d;
        TRK_SELECTED: state_d = TRK_IDLE;
        default:      state_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TRK_IDLE;
    else     state_q <= state_d;
  end

  assign reg_access = fire && is_top && (state_q == TRK_SELECTED);
endmodule

// File: rtl/swre_cfg_reg.sv
module swre_cfg_reg #(
  parameter int REG_W   = 21,
  parameter int DATA_W  = 16,
  parameter int DPD_BIT = 4,
  parameter logic [REG_W-1:0] RST_VAL = 21'h1A0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [REG_W-1:0]  value
);
  localparam logic [DATA_W-1:0] DPD_MASK = DATA_W'(1) << DPD_BIT;

  logic [DATA_W-1:0] low_q;
  assign value[DATA_W-1:0] = low_q;

  always_ff @(posedge clk) begin
    if (rst)        low_q <= RST_VAL[DATA_W-1:0];
    else if (wr_en) low_q <= wdata & ~DPD_MASK;
  end

  generate
    if (REG_W > DATA_W) begin : g_upper
      logic [REG_W-DATA_W-1:0] high_q;
      always_ff @(posedge clk) begin
        if (rst) high_q <= RST_VAL[REG_W-1:DATA_W];
      end
      assign value[REG_W-1:DATA_W] = high_q;
    end
  endgenerate
endmodule

// File: rtl/swre_top_word.sv
module swre_top_word #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (wr_en) word <= wdata;
  end
endmodule

// File: rtl/swre_resp.sv
module swre_resp #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  swre_pkg::rsp_kind_e kind_in,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                take,
  output logic                valid,
  output swre_pkg::rsp_kind_e kind,
  output logic [DATA_W-1:0]   data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      kind  <= swre_pkg::RSP_PASS;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      kind  <= kind_in;
      data  <= data_in;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swre_unit.sv
module swre_unit #(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 21,
  parameter int DPD_BIT = 4,
  parameter logic [DATA_W-1:0] SEL_CODE = '0,
  parameter logic [REG_W-1:0]  REG_RST  = 21'h1A0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic [DATA_W-1:0] res_data,
  output logic [REG_W-1:0]  cfg_reg
);
  import swre_pkg::*;

  logic              fire, is_top, reg_access;
  logic [DATA_W-1:0] top_word, rsp_data_d;
  rsp_kind_e         rsp_kind_d, rsp_kind_q;

  assign cyc_ready = !res_valid || res_ready;
  assign fire      = cyc_valid && cyc_ready;
  assign is_top    = &cyc_addr;

  swre_tracker #(.DATA_W(DATA_W), .SEL_CODE(SEL_CODE)) u_trk (
    .clk(clk), .rst(rst), .fire(fire), .is_write(cyc_write),
    .is_top(is_top), .wdata(cyc_wdata), .reg_access(reg_access)
  );

  swre_cfg_reg #(.REG_W(REG_W), .DATA_W(DATA_W), .DPD_BIT(DPD_BIT),
                 .RST_VAL(REG_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_access && cyc_write),
    .wdata(cyc_wdata), .value(cfg_reg)
  );

  swre_top_word #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst(rst),
    .wr_en(fire && is_top && cyc_write && !reg_access),
    .wdata(cyc_wdata), .word(top_word)
  );

  always_comb begin
    if (reg_access)  rsp_kind_d = RSP_REG;
    else if (is_top) rsp_kind_d = RSP_TOP;
    else             rsp_kind_d = RSP_PASS;

    if (cyc_write || !is_top) rsp_data_d = '0;
    else if (reg_access)      rsp_data_d = cfg_reg[DATA_W-1:0];
    else                      rsp_data_d = top_word;
  end

  swre_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .load(fire), .kind_in(rsp_kind_d),
    .data_in(rsp_data_d), .take(res_ready), .valid(res_valid),
    .kind(rsp_kind_q), .data(res_data)
  );

  assign res_kind = rsp_kind_q;
endmodule

// File: rtl/swre_unit_chk.sv
module swre_unit_chk #(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int REG_W   = 21,
  parameter int DPD_BIT = 4,
  parameter logic [REG_W-1:0] REG_RST = 21'h1A0003
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_valid,
  input logic              cyc_ready,
  input logic              cyc_write,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_kind,
  input logic [DATA_W-1:0] res_data,
  input logic [REG_W-1:0]  cfg_reg
);
  logic acc, acc_top;
  assign acc     = cyc_valid && cyc_ready;
  assign acc_top = acc && (&cyc_addr);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_kind)); // R2

  AST_PASS_RESULT: assert property (@(posedge clk) disable iff (rst)
    acc && !(&cyc_addr) |=> res_valid && res_kind == 2'd0 && res_data == '0); // R3

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    acc && cyc_write |=> res_data == '0); // R4

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(acc_top && cyc_write) |=> $stable(cfg_reg)); // R9

  AST_NO_DPD: assert property (@(posedge clk) disable iff (rst)
    !cfg_reg[DPD_BIT]); // R8

  generate
    if (REG_W > DATA_W) begin : g_up
      AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        cfg_reg[REG_W-1:DATA_W] == REG_RST[REG_W-1:DATA_W]); // R7
    end
  endgenerate
endmodule

bind swre_unit swre_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
  .DPD_BIT(DPD_BIT), .REG_RST(REG_RST)
) u_chk (
  .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
  .cyc_write(cyc_write), .cyc_addr(cyc_addr), .res_valid(res_valid),
  .res_ready(res_ready), .res_kind(res_kind), .res_data(res_data),
  .cfg_reg(cfg_reg)
);

// File: tb/swre_unit_test.sv
module swre_unit_test;
  localparam logic [20:0] T = 21'h1FFFFF;
  localparam int NV = 31;
  // {req[4], write, addr[21], wdata[16], kind[2], rdata[16], cfg[21]}
  localparam logic [80:0] VEC [NV] = '{
    {4'd4,  1'b1, T, 16'h1234, 2'd1, 16'h0000, 21'h1A0003}, // R4 write top word
    {4'd4,  1'b0, T, 16'h0000, 2'd1, 16'h1234, 21'h1A0003}, // R4 read top word
    {4'd4,  1'b0, T, 16'h0000, 2'd1, 16'h1234, 21'h1A0003},
    {4'd5,  1'b1, T, 16'h0000, 2'd1, 16'h0000, 21'h1A0003}, // R5 select
    {4'd8,  1'b1, T, 16'hFFFF, 2'd2, 16'h0000, 21'h1AFFEF}, // R5 R7 R8 program
    {4'd12, 1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF}, // R12 idle again
    {4'd6,  1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF},
    {4'd6,  1'b1, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF},
    {4'd6,  1'b0, T, 16'h0000, 2'd2, 16'hFFEF, 21'h1AFFEF}, // R6 read register
    {4'd3,  1'b0, 21'h000123, 16'h0000, 2'd0, 16'h0000, 21'h1AFFEF}, // R3
    {4'd9,  1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF},
    {4'd3,  1'b0, 21'h000000, 16'h0000, 2'd0, 16'h0000, 21'h1AFFEF}, // R3 R9 break
    {4'd9,  1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF},
    {4'd9,  1'b1, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF}, // R9 write too early
    {4'd9,  1'b1, T, 16'h5555, 2'd1, 16'h0000, 21'h1AFFEF}, // R9 ordinary write
    {4'd10, 1'b0, T, 16'h0000, 2'd1, 16'h5555, 21'h1AFFEF},
    {4'd10, 1'b0, T, 16'h0000, 2'd1, 16'h5555, 21'h1AFFEF},
    {4'd10, 1'b1, T, 16'h0001, 2'd1, 16'h0000, 21'h1AFFEF}, // R10 bad selector
    {4'd10, 1'b1, T, 16'h0A0A, 2'd1, 16'h0000, 21'h1AFFEF}, // R10 untouched
    {4'd11, 1'b0, T, 16'h0000, 2'd1, 16'h0A0A, 21'h1AFFEF},
    {4'd11, 1'b0, T, 16'h0000, 2'd1, 16'h0A0A, 21'h1AFFEF},
    {4'd11, 1'b0, T, 16'h0000, 2'd1, 16'h0A0A, 21'h1AFFEF}, // R11 restart
    {4'd11, 1'b0, T, 16'h0000, 2'd1, 16'h0A0A, 21'h1AFFEF},
    {4'd11, 1'b1, T, 16'h0000, 2'd1, 16'h0000, 21'h1AFFEF},
    {4'd8,  1'b1, T, 16'h1230, 2'd2, 16'h0000, 21'h1A1220}, // R8 R11 bit 4 cleared
    {4'd3,  1'b1, 21'h00F0F0, 16'h7777, 2'd0, 16'h0000, 21'h1A1220}, // R3 write
    {4'd9,  1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1A1220},
    {4'd9,  1'b0, T, 16'h0000, 2'd1, 16'h0000, 21'h1A1220},
    {4'd9,  1'b1, 21'h1FFFFE, 16'h0000, 2'd0, 16'h0000, 21'h1A1220}, // R9
    {4'd9,  1'b1, T, 16'hBEEF, 2'd1, 16'h0000, 21'h1A1220}, // R9 no entry
    {4'd4,  1'b0, T, 16'h0000, 2'd1, 16'hBEEF, 21'h1A1220}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cyc_valid = 1'b0, cyc_write = 1'b0, res_ready = 1'b1;
  logic [20:0] cyc_addr = '0;
  logic [15:0] cyc_wdata = '0;
  logic cyc_ready, res_valid;
  logic [1:0] res_kind;
  logic [15:0] res_data;
  logic [20:0] cfg_reg;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  swre_unit uut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_data(res_data), .cfg_reg(cfg_reg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one access with res_ready high, then check the result a cycle later
  task automatic run(input logic w, input logic [20:0] a, input logic [15:0] d,
                     input logic [1:0] ek, input logic [15:0] ed,
                     input logic [20:0] ec, input string req);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_write = w; cyc_addr = a; cyc_wdata = d;
    @(negedge clk);
    cyc_valid = 1'b0;
    check(res_valid && res_kind == ek && res_data == ed && cfg_reg == ec, req,
          "valid/kind/data/cfg", {res_valid, res_kind, res_data, 24'h0, cfg_reg},
          {1'b1, ek, ed, 24'h0, ec});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!res_valid && cfg_reg == 21'h1A0003 && cyc_ready, "R1", "reset",
          {res_valid, cyc_ready, cfg_reg}, {1'b0, 1'b1, 21'h1A0003});
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run(VEC[i][76], VEC[i][75:55], VEC[i][54:39], VEC[i][38:37],
          VEC[i][36:21], VEC[i][20:0], $sformatf("R%0d", VEC[i][80:77]));

    // R2 back-pressure: state is first-read after the last vector
    @(negedge clk);
    res_ready = 1'b0;
    cyc_valid = 1'b1; cyc_write = 1'b0; cyc_addr = T;
    @(negedge clk);
    check(res_valid && res_kind == 2'd1 && res_data == 16'hBEEF, "R2", "first stalled result",
          {res_kind, res_data}, {2'd1, 16'hBEEF});
    cyc_write = 1'b1; cyc_wdata = 16'h0000;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(!cyc_ready && res_valid && res_data == 16'hBEEF && res_kind == 2'd1, "R2",
            "hold while stalled", {cyc_ready, res_kind, res_data}, {1'b0, 2'd1, 16'hBEEF});
    end
    res_ready = 1'b1;
    @(negedge clk);
    cyc_valid = 1'b0;
    check(res_valid && res_kind == 2'd1 && res_data == 16'h0, "R2", "drained then accepted",
          {res_kind, res_data}, {2'd1, 16'h0});
    run(1'b1, T, 16'h0101, 2'd2, 16'h0, 21'h1A0101, "R5");

    // R1 reset in the middle of a pattern
    run(1'b0, T, 16'h0, 2'd1, 16'h0000, 21'h1A0101, "R4");
    run(1'b0, T, 16'h0, 2'd1, 16'h0000, 21'h1A0101, "R4");
    run(1'b1, T, 16'h0, 2'd1, 16'h0000, 21'h1A0101, "R4");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!res_valid && cfg_reg == 21'h1A0003, "R1", "mid-pattern reset",
          {res_valid, cfg_reg}, {1'b0, 21'h1A0003});
    rst = 1'b0;
    run(1'b1, T, 16'h4444, 2'd1, 16'h0000, 21'h1A0003, "R1");
    run(1'b0, T, 16'h0000, 2'd1, 16'h4444, 21'h1A0003, "R1");

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule